// File: doc/BRIEF.md
# Status Register Privilege Controller

This block owns a processor's 16-bit status word and its two stack pointers: the one currently in use as A7 and the saved one for the other privilege level. A decoder upstream hands it one status operation per strobe, together with an immediate or operand value and the program counter of the opcode. The block reads or rewrites the status word, enforces supervisor-only operations, swaps the stack pointers whenever the supervisor flag flips, and signals a privilege-violation exception when a user-mode program tries a protected operation. Memory access, instruction decoding and exception frame building stay outside.

The control core is a two-state machine. In state `ST_RUN` the block accepts strobes. The transition `run_to_halt` fires when a stop operation is accepted. In state `ST_HALT` the block ignores strobes. The transition `halt_to_run` fires on the wake input. Every accepted operation takes effect on a single clock edge, and every result is registered.

Status word layout, from low bit to high: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 extend. Bits 7:5 are always zero. Bits 10:8 hold the interrupt mask, bit 13 is the supervisor flag and bit 15 is trace. Every other bit is always zero, so the writable pattern is 0xA71F.

Top module: `sr_priv_ctrl`

## Requirements
- R1: After reset the status word is 0x2700, `sp_active` equals RESET_SSP, `sp_other` equals RESET_USP, `stopped`, `exc_req` and `rd_valid` are low, and `pc_out` is zero.
- R2: Every write of the status word keeps only the bits in mask 0xA71F. Bits 7:5 of the low byte and every high-byte bit outside 0xA7 always read zero.
- R3: Code 0 (read SR) returns the full status word, and code 1 (read CCR) returns the low byte zero-extended. The result appears on `rd_value` with `rd_valid` high for one cycle after the strobe edge. Both codes work in user mode and leave the status word unchanged.
- R4: Code 2 (write CCR) loads the operand's low byte. Codes 4, 5 and 6 (OR, AND and XOR of the operand's low byte into the CCR) change only the low byte. All four codes are allowed in user mode.
- R5: In supervisor mode, code 3 (write SR) loads the operand into the whole status word. Codes 7, 8 and 9 (OR, AND and XOR of the operand into the SR) combine the operand with the whole status word.
- R6: In user mode (bit 13 clear), codes 3, 7, 8, 9 and 10 leave the status word and stack pointers unchanged. They set `pc_out` to `pc_in` minus 2 and raise `exc_req` for one cycle with `exc_vector` 0x20.
- R7: A write that changes bit 13 exchanges `sp_active` and `sp_other` on the same edge. A write that keeps bit 13 leaves both pointers unchanged.
- R8: Each accepted operation that does not fault sets `pc_out` to `pc_in` with `exc_req` low. Codes 11 to 15 and cycles with `op_valid` low change no output.
- R9: Code 10 (stop) loads the operand into the status word under the rules of R2, R6 and R7. It then enters `ST_HALT` with `stopped` high.
- R10: In `ST_HALT` every strobe is ignored. `irq_wake` returns the block to `ST_RUN`, and the strobe in that same cycle is also ignored. In `ST_RUN`, `irq_wake` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code (0 to 10 defined) |
| op_value | input | 16 | Immediate or operand value |
| pc_in | input | PC_W | Address following the opcode |
| irq_wake | input | 1 | Wake request that leaves the stopped state |
| sr_out | output | 16 | Current status word |
| sp_active | output | SP_W | Stack pointer in use as A7 |
| sp_other | output | SP_W | Saved stack pointer of the other level |
| rd_value | output | 16 | Result of the last read operation |
| rd_valid | output | 1 | One-cycle pulse for a fresh read result |
| pc_out | output | PC_W | Program counter after the last operation |
| exc_req | output | 1 | Privilege-violation request pulse |
| exc_vector | output | 8 | Vector offset, 0x20 while `exc_req` is high |
| stopped | output | 1 | High in state `ST_HALT` |

## Verification
Every result of this block (status word, pointer swap, read value, program counter, exception pulse and stopped flag) is due exactly one rising edge after the cycle that carries the strobe, and nothing changes later than that. The bench drives each stimulus on a falling edge and advances its reference model at the same moment. On the next falling edge it compares every output with the model, half a period after the only edge that could have changed them. Idle cycles and ignored strobes are checked the same way, so a stray update on any later cycle would also be caught.

// File: rtl/sr_priv_pkg.sv
package sr_priv_pkg;

    typedef enum logic [3:0] {
        OP_RD_SR   = 4'd0,
        OP_RD_CCR  = 4'd1,
        OP_WR_CCR  = 4'd2,
        OP_WR_SR   = 4'd3,
        OP_OR_CCR  = 4'd4,
        OP_AND_CCR = 4'd5,
        OP_XOR_CCR = 4'd6,
        OP_OR_SR   = 4'd7,
        OP_AND_SR  = 4'd8,
        OP_XOR_SR  = 4'd9,
        OP_STOP    = 4'd10
    } sr_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } ctl_state_e;

    localparam int          SR_W       = 16;
    localparam int          SUP_BIT    = 13;
    localparam logic [15:0] SR_KEEP    = 16'hA71F;
    localparam logic [7:0]  CCR_KEEP   = 8'h1F;
    localparam logic [7:0]  PRIV_VEC   = 8'h20;
    localparam logic [15:0] SR_AT_RST  = 16'h2700;

endpackage

// File: rtl/sr_alu.sv
module sr_alu
    import sr_priv_pkg::*;
(
    input  logic [15:0] sr_cur,
    input  logic [3:0]  op_raw,
    input  logic [15:0] opnd,
    output logic [15:0] sr_new,
    output logic [15:0] rd_data,
    output logic        is_defined,
    output logic        is_priv,
    output logic        is_write,
    output logic        is_read,
    output logic        is_stop
);
    sr_op_e op;
    logic [7:0] ccr_res;

    assign op = sr_op_e'(op_raw);

    always_comb begin
        sr_new     = sr_cur;
        rd_data    = 16'h0000;
        ccr_res    = sr_cur[7:0];
        is_defined = 1'b1;
        is_priv    = 1'b0;
        is_write   = 1'b0;
        is_read    = 1'b0;
        is_stop    = 1'b0;
        unique case (op)
            OP_RD_SR: begin
                is_read = 1'b1;
                rd_data = sr_cur;
            end
            OP_RD_CCR: begin
                is_read = 1'b1;
                rd_data = {8'h00, sr_cur[7:0]};
            end
            OP_WR_CCR, OP_OR_CCR, OP_AND_CCR, OP_XOR_CCR: begin
                is_write = 1'b1;
                if (op == OP_WR_CCR)       ccr_res = opnd[7:0];
                else if (op == OP_OR_CCR)  ccr_res = sr_cur[7:0] | opnd[7:0];
                else if (op == OP_AND_CCR) ccr_res = sr_cur[7:0] & opnd[7:0];
                else                       ccr_res = sr_cur[7:0] ^ opnd[7:0];
                sr_new = {sr_cur[15:8], ccr_res & CCR_KEEP};
            end
            OP_WR_SR, OP_STOP: begin
                is_write = 1'b1;
                is_priv  = 1'b1;
                is_stop  = (op == OP_STOP);
                sr_new   = opnd & SR_KEEP;
            end
            OP_OR_SR: begin
                is_write = 1'b1;
                is_priv  = 1'b1;
                sr_new   = (sr_cur | opnd) & SR_KEEP;
            end
            OP_AND_SR: begin
                is_write = 1'b1;
                is_priv  = 1'b1;
                sr_new   = (sr_cur & opnd) & SR_KEEP;
            end
            OP_XOR_SR: begin
                is_write = 1'b1;
                is_priv  = 1'b1;
                sr_new   = (sr_cur ^ opnd) & SR_KEEP;
            end
            default: is_defined = 1'b0;
        endcase
    end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int                SP_W      = 32,
    parameter logic [SP_W-1:0]   RESET_SSP = '0,
    parameter logic [SP_W-1:0]   RESET_USP = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            swap_en,
    output logic [SP_W-1:0] sp_act,
    output logic [SP_W-1:0] sp_oth
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_act <= RESET_SSP;
            sp_oth <= RESET_USP;
        end else if (swap_en) begin
            sp_act <= sp_oth;
            sp_oth <= sp_act;
        end
    end

    // R7
    sp_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_en |=> (sp_act == $past(sp_oth)) && (sp_oth == $past(sp_act)));

    // R7
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_en |=> $stable(sp_act) && $stable(sp_oth));
endmodule

// File: rtl/sr_priv_ctrl.sv
module sr_priv_ctrl
    import sr_priv_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter int              SP_W      = 32,
    parameter logic [SP_W-1:0] RESET_SSP = 32'h0000_8000,
    parameter logic [SP_W-1:0] RESET_USP = 32'h0000_4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [15:0]     op_value,
    input  logic [PC_W-1:0] pc_in,
    input  logic            irq_wake,
    output logic [15:0]     sr_out,
    output logic [SP_W-1:0] sp_active,
    output logic [SP_W-1:0] sp_other,
    output logic [15:0]     rd_value,
    output logic            rd_valid,
    output logic [PC_W-1:0] pc_out,
    output logic            exc_req,
    output logic [7:0]      exc_vector,
    output logic            stopped
);
    localparam logic [PC_W-1:0] OPC_BYTES = PC_W'(2);

    ctl_state_e state_q, state_d;
    logic [15:0] sr_q, sr_nx, rd_nx;
    logic is_def, is_priv, is_wr, is_rd, is_stop;
    logic accept, viol, commit, swap;

    sr_alu u_alu (
        .sr_cur     (sr_q),
        .op_raw     (op_code),
        .opnd       (op_value),
        .sr_new     (sr_nx),
        .rd_data    (rd_nx),
        .is_defined (is_def),
        .is_priv    (is_priv),
        .is_write   (is_wr),
        .is_read    (is_rd),
        .is_stop    (is_stop)
    );

    assign accept = op_valid && (state_q == ST_RUN) && is_def;
    assign viol   = accept && is_priv && !sr_q[SUP_BIT];
    assign commit = accept && !viol && is_wr;
    assign swap   = commit && (sr_nx[SUP_BIT] != sr_q[SUP_BIT]);

    sp_bank #(
        .SP_W      (SP_W),
        .RESET_SSP (RESET_SSP),
        .RESET_USP (RESET_USP)
    ) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .swap_en (swap),
        .sp_act  (sp_active),
        .sp_oth  (sp_other)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions: run_to_halt, halt_to_run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (commit && is_stop) state_d = ST_HALT;
            ST_HALT: if (irq_wake)          state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q     <= SR_AT_RST;
            rd_value <= 16'h0000;
            rd_valid <= 1'b0;
            pc_out   <= '0;
            exc_req  <= 1'b0;
        end else begin
            rd_valid <= accept && is_rd;
            exc_req  <= viol;
            if (commit) sr_q <= sr_nx;
            if (accept && is_rd) rd_value <= rd_nx;
            if (viol)        pc_out <= pc_in - OPC_BYTES;
            else if (accept) pc_out <= pc_in;
        end
    end

    assign sr_out     = sr_q;
    assign stopped    = (state_q == ST_HALT);
    assign exc_vector = exc_req ? PRIV_VEC : 8'h00;

    // R2
    sr_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q & ~SR_KEEP) == 16'h0000);

    // R6
    priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> $stable(sr_q) && exc_req && (pc_out == $past(pc_in) - OPC_BYTES));

    // R6
    exc_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> exc_vector == PRIV_VEC);

    // R7
    sup_flip_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q[SUP_BIT] != $past(sr_q[SUP_BIT])) |-> (sp_active == $past(sp_other)));

    // R4
    ccr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_code inside {4'd2, 4'd4, 4'd5, 4'd6})) |=> sr_q[15:8] == $past(sr_q[15:8]));

    // R10
    halt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !irq_wake) |=> $stable(sr_q) && stopped && !rd_valid && !exc_req);
endmodule

// File: tb/test_sr_priv_ctrl.sv
module test_sr_priv_ctrl;
    localparam logic [31:0] SSP0 = 32'h0000_8000;
    localparam logic [31:0] USP0 = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [15:0] op_value = '0;
    logic [31:0] pc_in = '0;
    logic        irq_wake = 1'b0;
    logic [15:0] sr_out, rd_value;
    logic [31:0] sp_active, sp_other, pc_out;
    logic        rd_valid, exc_req, stopped;
    logic [7:0]  exc_vector;

    int total = 0;
    int bad = 0;

    // reference state
    logic [15:0] m_sr, m_rd;
    logic [31:0] m_spa, m_spo, m_pc;
    bit          m_halt, m_rdv, m_exc;

    always #10 clk = ~clk;

    sr_priv_ctrl #(.RESET_SSP(SSP0), .RESET_USP(USP0)) i_sr_priv_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_value(op_value), .pc_in(pc_in), .irq_wake(irq_wake),
        .sr_out(sr_out), .sp_active(sp_active), .sp_other(sp_other),
        .rd_value(rd_value), .rd_valid(rd_valid), .pc_out(pc_out),
        .exc_req(exc_req), .exc_vector(exc_vector), .stopped(stopped)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "sr_out",     {16'h0, sr_out},   {16'h0, m_sr});
        chk(req, "sp_active",  sp_active,         m_spa);
        chk(req, "sp_other",   sp_other,          m_spo);
        chk(req, "pc_out",     pc_out,            m_pc);
        chk(req, "rd_valid",   {31'h0, rd_valid}, {31'h0, m_rdv});
        chk(req, "rd_value",   {16'h0, rd_value}, {16'h0, m_rd});
        chk(req, "exc_req",    {31'h0, exc_req},  {31'h0, m_exc});
        chk(req, "exc_vector", {24'h0, exc_vector}, m_exc ? 32'h20 : 32'h0);
        chk(req, "stopped",    {31'h0, stopped},  {31'h0, m_halt});
    endtask

    task automatic model_reset();
        m_sr = 16'h2700; m_spa = SSP0; m_spo = USP0; m_pc = 0;
        m_rd = 0; m_halt = 0; m_rdv = 0; m_exc = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_valid = 1'b0; irq_wake = 1'b0;
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
    endtask

    // drive one cycle (at a falling edge), advance the model, check one edge later
    task automatic step(input bit vld, input int op, input logic [15:0] v,
                        input logic [31:0] pc, input bit wake, input string req);
        logic [15:0] nsr;
        logic [31:0] t;
        bit priv;
        op_valid = vld; op_code = op[3:0]; op_value = v; pc_in = pc; irq_wake = wake;
        m_rdv = 0; m_exc = 0;
        if (m_halt) begin
            if (wake) m_halt = 0;
        end else if (vld && op <= 10) begin
            priv = (op == 3) || (op >= 7);
            if (priv && !m_sr[13]) begin
                m_exc = 1;
                m_pc = pc - 2;
            end else begin
                m_pc = pc;
                nsr = m_sr;
                case (op)
                    0: begin m_rd = m_sr; m_rdv = 1; end
                    1: begin m_rd = {8'h00, m_sr[7:0]}; m_rdv = 1; end
                    2: nsr[7:0] = v[7:0] & 8'h1F;
                    4: nsr[7:0] = (m_sr[7:0] | v[7:0]) & 8'h1F;
                    5: nsr[7:0] = (m_sr[7:0] & v[7:0]) & 8'h1F;
                    6: nsr[7:0] = (m_sr[7:0] ^ v[7:0]) & 8'h1F;
                    3, 10: nsr = v & 16'hA71F;
                    7: nsr = (m_sr | v) & 16'hA71F;
                    8: nsr = (m_sr & v) & 16'hA71F;
                    9: nsr = (m_sr ^ v) & 16'hA71F;
                    default: ;
                endcase
                if (nsr[13] != m_sr[13]) begin
                    t = m_spa; m_spa = m_spo; m_spo = t;
                end
                m_sr = nsr;
                if (op == 10) m_halt = 1;
            end
        end
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        #4_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();                                        // R1
        step(0, 0, 16'h0, 32'h100, 0, "R8");               // idle
        step(1, 0, 16'h0, 32'h102, 0, "R3");               // read SR
        step(1, 2, 16'hFFFF, 32'h104, 0, "R4");            // write CCR, R2 mask
        step(1, 1, 16'h0, 32'h106, 0, "R3");               // read CCR
        step(1, 5, 16'h0005, 32'h108, 0, "R4");            // AND CCR
        step(1, 6, 16'hFF1F, 32'h10A, 0, "R4");            // XOR CCR keeps high byte
        step(1, 4, 16'h0001, 32'h10C, 0, "R4");            // OR CCR
        step(1, 3, 16'hFFFF, 32'h10E, 0, "R5");            // write SR, R2 mask, no swap
        step(1, 7, 16'h2000, 32'h110, 0, "R7");            // OR SR keeps S, no swap
        step(1, 8, 16'hDFFF, 32'h112, 0, "R7");            // AND SR clears S -> swap
        step(1, 0, 16'h0, 32'h114, 0, "R3");               // read SR in user mode
        step(1, 3, 16'h2700, 32'h116, 0, "R6");            // privileged write faults
        step(0, 0, 16'h0, 32'h118, 0, "R6");               // exc pulse ends
        step(1, 7, 16'h2000, 32'h11A, 0, "R6");
        step(1, 9, 16'h2000, 32'h11C, 0, "R6");
        step(1, 10, 16'h2000, 32'h11E, 0, "R6");           // stop in user mode faults
        step(1, 2, 16'h000A, 32'h120, 0, "R4");            // CCR write allowed in user
        step(1, 12, 16'hFFFF, 32'h122, 0, "R8");           // undefined code ignored
        step(1, 15, 16'h0000, 32'h124, 0, "R8");
        step(1, 1, 16'h0, 32'h126, 1, "R10");              // wake in run: no effect
        do_reset();
        step(1, 9, 16'h2000, 32'h200, 0, "R7");            // XOR SR flips S -> swap
        do_reset();
        step(1, 10, 16'h0000, 32'h300, 0, "R9");           // stop to user, swap, halt
        step(1, 3, 16'h2700, 32'h302, 0, "R10");           // ignored while halted
        step(1, 0, 16'h0, 32'h304, 0, "R10");
        step(0, 0, 16'h0, 32'h306, 0, "R10");
        step(1, 2, 16'h001F, 32'h308, 1, "R10");           // wake; same strobe ignored
        step(1, 2, 16'h001F, 32'h30A, 0, "R4");            // running again
        do_reset();
        step(1, 10, 16'h2513, 32'h400, 0, "R9");           // stop staying supervisor
        step(0, 0, 16'h0, 32'h402, 1, "R10");
        step(1, 8, 16'hFFFF, 32'h404, 0, "R5");
        step(0, 0, 16'h0, 32'h406, 0, "R8");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule